// File: doc/BRIEF.md
# Kick-Updated Fractional Clock Enable Generator

This block produces a clock-enable stream for a derived core clock whose average rate is a programmable fraction of the parent clock, in steps of 1/32. The fraction is held as a 5-bit "drop count" Z: over every 32 parent cycles the enable is high for exactly 32 − Z cycles, so Z = 0 gives the full parent rate and Z = 31 gives 1/32 of it. Downstream logic gates its work with the enable, and the clock itself is never switched.

Software sets the ratio through a small register interface. Writing the ratio register only stages a value. The new ratio takes effect when software writes 1 to the update bit in a second register. The block then loads the staged value into the active divider at the next 32-cycle period boundary and clears the update bit one cycle later. While the update bit reads 1, software must wait before it starts another update.

Top module: `frac_clk_gate`

## Requirements
- R1: With Z held in bits 12:8 of the ratio register (offset 0xE0) and committed, every 32-cycle period counted from reset release contains exactly 32 − Z enable cycles.
- R2: With Z = 0 the enable is high on every cycle, and with Z = 31 it is high on exactly one cycle per period.
- R3: All 32 bits of the ratio register are stored and read back unchanged, so bits outside 12:8 survive a read-modify-write.
- R4: In the update register (offset 0x04), writing 1 to bit 31 sets the update bit. Writing 0 to bit 31 leaves it unchanged, and bits 30:0 are stored and read back.
- R5: The update bit reads 1 while an update is pending. It returns to 0 no more than 33 cycles after it was set, and exactly one cycle after the new ratio became active, which is the second cycle of a period.
- R6: The active ratio changes only between the last cycle of one period and the first cycle of the next, so no period mixes two ratios.
- R7: A ratio write made while the update bit is set is stored and reads back. The pending update still applies the value staged when the update bit was written, and the newer value applies only after the next update request.
- R8: After reset the ratio register and the update register read 0, and the enable runs at full rate.
- R9: Writing the ratio register without an update request leaves the enable rate unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 8 | Register byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| clk_en | output | 1 | Enable pulse for the derived clock domain |

## Verification
If the active ratio is loaded at the wrong time, or the accumulator is not at zero when a period starts, the enable count in the very next aligned 32-cycle window differs from 32 − Z. That shows up within one period of the update. If the commit is missing or late, the update bit stays high past 33 cycles or clears in a cycle other than the second of a period. This is visible on the first poll that reads the wrong value. A staged value that leaks into the divider without an update request, or the wrong snapshot applied, changes the count in the next window.

// File: rtl/fcg_pkg.sv
// Shared constants for the fractional clock-enable generator.
// Assumes the ratio granularity is a power of two (2**FRAC_W steps).
package fcg_pkg;
    localparam int FRAC_W   = 5;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int RATIO_OFS = 'hE0;
    localparam int UPD_OFS   = 'h04;
    localparam int FIELD_LSB = 8;
    localparam int UPD_BIT   = 31;
endpackage

// File: rtl/fcg_regs.sv
// Register file: ratio register (staged drop count) and update register
// (self-clearing request bit). Reads are combinational. Assumes one
// access per cycle and that commit_done pulses once per applied update.
module fcg_regs #(
    parameter int ADDR_W    = fcg_pkg::ADDR_W,
    parameter int DATA_W    = fcg_pkg::DATA_W,
    parameter int FRAC_W    = fcg_pkg::FRAC_W,
    parameter int RATIO_OFS = fcg_pkg::RATIO_OFS,
    parameter int UPD_OFS   = fcg_pkg::UPD_OFS,
    parameter int FIELD_LSB = fcg_pkg::FIELD_LSB,
    parameter int UPD_BIT   = fcg_pkg::UPD_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              commit_done,
    output logic [DATA_W-1:0] rdata,
    output logic [FRAC_W-1:0] staged_frac,
    output logic              upd_req,
    output logic              upd_pending
);
    localparam int LIMIT = (1 << FRAC_W) + 1;

    logic [DATA_W-1:0] ratio_q;
    logic [DATA_W-1:0] upd_q;
    logic              ratio_wr;
    logic              upd_wr;

    assign ratio_wr    = wr_en && (addr == ADDR_W'(RATIO_OFS));
    assign upd_wr      = wr_en && (addr == ADDR_W'(UPD_OFS));
    assign upd_req     = upd_wr && wdata[UPD_BIT];
    assign staged_frac = ratio_q[FIELD_LSB +: FRAC_W];
    assign upd_pending = upd_q[UPD_BIT];

    // Ratio register: plain storage of the whole word.
    always_ff @(posedge clk) begin
        if (!rst_n)        ratio_q <= '0;
        else if (ratio_wr) ratio_q <= wdata;
    end

    // Update register: low bits stored, request bit set-by-write, cleared by commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_q <= '0;
        end else begin
            if (upd_wr) upd_q[UPD_BIT-1:0] <= wdata[UPD_BIT-1:0];
            if (upd_req)          upd_q[UPD_BIT] <= 1'b1;
            else if (commit_done) upd_q[UPD_BIT] <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        if (addr == ADDR_W'(RATIO_OFS))    rdata = ratio_q;
        else if (addr == ADDR_W'(UPD_OFS)) rdata = upd_q;
        else                               rdata = '0;
    end

    // Checker counter: cycles the request bit has stayed set.
    logic [FRAC_W+1:0] pend_age;
    always_ff @(posedge clk) begin
        if (!rst_n || !upd_pending) pend_age <= '0;
        else                        pend_age <= pend_age + 1'b1;
    end

    // R5
    upd_clear_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(upd_pending) |-> $past(commit_done));
    // R5
    upd_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_age <= (FRAC_W+2)'(LIMIT));
endmodule

// File: rtl/fcg_commit.sv
// Period counter and commit logic. Snapshots the staged ratio when an
// update is requested and loads it into the active ratio at the last
// cycle of a period; flags completion one cycle later.
module fcg_commit #(
    parameter int FRAC_W = fcg_pkg::FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_req,
    input  logic              upd_pending,
    input  logic [FRAC_W-1:0] staged_frac,
    output logic [FRAC_W-1:0] active_frac,
    output logic [FRAC_W-1:0] phase,
    output logic              commit_done
);
    localparam logic [FRAC_W-1:0] LAST = '1;

    logic [FRAC_W-1:0] snap_q;
    logic              at_end;

    assign at_end = (phase == LAST);

    // Free-running period position, wraps every 2**FRAC_W cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + 1'b1;
    end

    // Capture the ratio that this update request will apply.
    always_ff @(posedge clk) begin
        if (!rst_n)       snap_q <= '0;
        else if (upd_req) snap_q <= staged_frac;
    end

    // Apply the snapshot at the period boundary and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_frac <= '0;
            commit_done <= 1'b0;
        end else begin
            commit_done <= at_end && upd_pending;
            if (at_end && upd_pending) active_frac <= snap_q;
        end
    end

    // R6
    ratio_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_frac) |-> (phase == '0));
endmodule

// File: rtl/fcg_accum.sv
// Enable generator: a phase accumulator adds the multiplier (2**FRAC_W
// minus the drop count) every cycle and asserts the enable on carry.
// Assumes the ratio changes only at period start, when the accumulator is 0.
module fcg_accum #(
    parameter int FRAC_W = fcg_pkg::FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FRAC_W-1:0] active_frac,
    input  logic [FRAC_W-1:0] phase,
    output logic              clk_en
);
    localparam int STEPS = 1 << FRAC_W;

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   mult;
    logic [FRAC_W:0]   sum;

    assign mult   = (FRAC_W+1)'(STEPS) - {1'b0, active_frac};
    assign sum    = {1'b0, acc_q} + mult;
    assign clk_en = sum[FRAC_W];

    // Accumulate modulo 2**FRAC_W.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= sum[FRAC_W-1:0];
    end

    // Checker counter: enables seen so far in this period.
    logic [FRAC_W:0] en_tally;
    always_ff @(posedge clk) begin
        if (!rst_n || phase == '1) en_tally <= '0;
        else                       en_tally <= en_tally + {{FRAC_W{1'b0}}, clk_en};
    end

    // R1
    period_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == '1) |-> (en_tally + {{FRAC_W{1'b0}}, clk_en} == mult));
    // R2
    full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_frac == '0) |-> clk_en);
    // R6
    acc_zero_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == '0) |-> (acc_q == '0));
endmodule

// File: rtl/frac_clk_gate.sv
// Top level: register file, commit logic and enable generator.
// Assumes a single-cycle write strobe and combinational reads.
module frac_clk_gate #(
    parameter int FRAC_W = fcg_pkg::FRAC_W,
    parameter int ADDR_W = fcg_pkg::ADDR_W,
    parameter int DATA_W = fcg_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              clk_en
);
    logic [FRAC_W-1:0] staged_frac;
    logic [FRAC_W-1:0] active_frac;
    logic [FRAC_W-1:0] phase;
    logic              upd_req;
    logic              upd_pending;
    logic              commit_done;

    fcg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .commit_done(commit_done), .rdata(rdata), .staged_frac(staged_frac),
        .upd_req(upd_req), .upd_pending(upd_pending)
    );

    fcg_commit #(.FRAC_W(FRAC_W)) u_commit (
        .clk(clk), .rst_n(rst_n), .upd_req(upd_req), .upd_pending(upd_pending),
        .staged_frac(staged_frac), .active_frac(active_frac), .phase(phase),
        .commit_done(commit_done)
    );

    fcg_accum #(.FRAC_W(FRAC_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .active_frac(active_frac), .phase(phase),
        .clk_en(clk_en)
    );
endmodule

// File: tb/test_frac_clk_gate.sv
module test_frac_clk_gate;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] RATIO_A = 8'hE0;
    localparam logic [7:0] UPD_A   = 8'h04;
    localparam logic [31:0] FMASK  = 32'h0000_1F00;
    localparam logic [31:0] UBIT   = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        clk_en;

    int n_chk = 0;
    int n_fail = 0;
    int phase = 0;
    int en_cnt = 0;
    bit done = 0;

    frac_clk_gate i_frac_clk_gate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .clk_en(clk_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock: count enable before the edge, then return at the negedge.
    task automatic step();
        if (clk_en) en_cnt++;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        phase = (phase + 1) % 32;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        step();
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic align();
        while (phase != 0) step();
    endtask

    // Count enables over one aligned period.
    task automatic window(output int cnt);
        align();
        en_cnt = 0;
        for (int i = 0; i < 32; i++) step();
        cnt = en_cnt;
    endtask

    // Poll the update bit until clear; returns cycles waited and phase at clear.
    task automatic wait_clear(string req, output int waited);
        logic [31:0] v;
        waited = 0;
        rd(UPD_A, v);
        while (v[31] && waited < 100) begin
            step(); waited++; rd(UPD_A, v);
        end
        check(req, (waited <= 33) ? 1 : 0, 1);
        check(req, phase, 1);
    endtask

    initial begin
        logic [31:0] v;
        int cnt, w;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1; phase = 0;

        // R8 reset state
        rd(RATIO_A, v); check("R8", v, 0);
        rd(UPD_A, v);   check("R8", v, 0);
        window(cnt);    check("R8", cnt, 32);

        // R3 full-word storage
        wr(RATIO_A, 32'hA5A5_E35A);
        rd(RATIO_A, v); check("R3", v, 32'hA5A5_E35A);
        // R9 no effect without update request (field = 3)
        window(cnt); check("R9", cnt, 32);

        // R4 other bits stored, write of 0 to bit 31 does not clear
        wr(UPD_A, UBIT | 32'h0123_4567);
        rd(UPD_A, v); check("R4", v, UBIT | 32'h0123_4567);
        wr(UPD_A, 32'h0000_00FF);
        rd(UPD_A, v); check("R4", v, UBIT | 32'h0000_00FF);
        wait_clear("R5", w);
        window(cnt); check("R1", cnt, 29);

        // Sweep of every drop count with read-modify-write.
        for (int z = 0; z < 32; z++) begin
            rd(RATIO_A, v);
            wr(RATIO_A, (v & ~FMASK) | (32'(z) << 8));
            rd(RATIO_A, v);
            check("R3", v, 32'hA5A5_E05A | (32'(z) << 8));
            wr(UPD_A, UBIT);
            rd(UPD_A, v); check("R5", v[31], 1);
            wait_clear("R5", w);
            window(cnt);
            if (z == 0 || z == 31) check("R2", cnt, 32 - z);
            else                   check("R1", cnt, 32 - z);
        end

        // R7 write while pending: pending update applies the older value
        wr(RATIO_A, 32'(5) << 8);
        wr(UPD_A, UBIT);
        wr(RATIO_A, 32'(9) << 8);
        rd(RATIO_A, v); check("R7", v, 32'(9) << 8);
        wait_clear("R7", w);
        window(cnt); check("R7", cnt, 27);
        window(cnt); check("R7", cnt, 27);
        wr(UPD_A, UBIT);
        wait_clear("R7", w);
        window(cnt); check("R7", cnt, 23);

        // R6 request issued late in a period applies from a later boundary only
        wr(RATIO_A, 32'(16) << 8);
        while (phase != 30) step();
        wr(UPD_A, UBIT);
        en_cnt = 0;
        step();
        check("R6", phase, 0);
        window(cnt); check("R6", cnt, 16);

        done = 1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule